// File: doc/BRIEF.md
# Load-Use Hazard Stall Controller

This block sits in the front end of a five-stage in-order pipeline. It holds the program counter, the fetch-to-decode instruction register and the control word and target register number of the instruction entering execute. Each cycle it compares the register loaded by a memory-read instruction in the execute-entry register with the two source register fields of the instruction now in decode. When they match, the loaded value cannot yet be forwarded, so the block stalls for exactly one cycle.

During the stall cycle both write enables are deasserted. The PC and the decode register keep their values, so the dependent instruction is decoded again and the next instruction is fetched again. An all-zero control word enters execute as a bubble, so the later stages do nothing for that slot. The bubble has its memory-read bit clear, so the same pair cannot raise a second stall. The loaded value then reaches execute through the pipeline's forwarding paths, which are outside this block.

Top module: `hazard_stall_unit`

## Requirements
- R1: While `rst` is high at a rising edge, `pc`, `ifIdInstr`, `idExCtrl` and `idExRt` are cleared to zero in the next cycle.
- R2: `stall` is high exactly when bit 0 of `idExCtrl` (the memory-read flag) is set and `idExRt` equals either decode-instruction bits 25:21 (first source) or bits 20:16 (second source).
- R3: `pcWriteEn` and `ifIdWriteEn` are both low in a cycle where `stall` is high, and both high in any other cycle.
- R4: After a stall cycle, `pc` and `ifIdInstr` keep the values they had during that cycle.
- R5: After a stall cycle, `idExCtrl` is all zero (the bubble).
- R6: After a non-stall cycle, `pc` is its previous value plus 4, `ifIdInstr` takes `fetchInstr`, `idExCtrl` takes `decodeCtrl`, and `idExRt` takes bits 20:16 of the previous `ifIdInstr`.
- R7: `stall` is never high in two consecutive cycles, so each load-use pair costs exactly one cycle.
- R8: A load followed by an instruction whose source fields both differ from the load's target causes no stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| fetchInstr | input | 32 | Instruction read at the current PC |
| decodeCtrl | input | 8 | Control word decoded from `ifIdInstr`; bit 0 is memory read |
| pc | output | 32 | Program counter |
| ifIdInstr | output | 32 | Instruction held in the decode stage |
| idExCtrl | output | 8 | Control word entering execute |
| idExRt | output | 5 | Target register number entering execute |
| pcWriteEn | output | 1 | PC update enable |
| ifIdWriteEn | output | 1 | Decode register update enable |
| stall | output | 1 | Load-use hazard detected this cycle |

## Verification
Random instruction streams draw their register fields from only four values and set the memory-read bit often. This produces frequent matches on the first source, the second source and both sources, including stall requests on consecutive cycles, and every cycle is compared with a bench model. Two directed sequences separate the two cases the block must tell apart. A load followed by a dependent add must cost exactly one bubble with PC and decode held. A load followed by an independent add must cost none.

// File: rtl/hzd_pkg.sv
package hzd_pkg;

  // Strobes driven by the hazard control toward the pipeline registers.
  typedef struct packed {
    logic pcWrite;    // PC may advance
    logic ifIdWrite;  // decode register may load
    logic bubble;     // zero the control word entering execute
  } stallStrobes_t;

endpackage

// File: rtl/hzd_ctrl.sv
module hzd_ctrl
  import hzd_pkg::*;
#(
  parameter int unsigned XLEN   = 32,
  parameter int unsigned REG_W  = 5,
  parameter int unsigned RS_LSB = 21,
  parameter int unsigned RT_LSB = 16
) (
  input  logic             idExMemRead,
  input  logic [REG_W-1:0] idExRt,
  input  logic [XLEN-1:0]  ifIdInstr,
  output logic             hazard,
  output stallStrobes_t    strobes
);

  localparam int unsigned NUM_SRC = 2;

  logic [NUM_SRC-1:0] srcMatch;

  // One comparator per source-operand field of the decoding instruction.
  for (genvar g = 0; g < NUM_SRC; g++) begin : gSrc
    localparam int unsigned FIELD_LSB = (g == 0) ? RS_LSB : RT_LSB;
    assign srcMatch[g] = (ifIdInstr[FIELD_LSB +: REG_W] == idExRt);
  end

  always_comb begin
    hazard            = idExMemRead && (|srcMatch);
    strobes.pcWrite   = !hazard;
    strobes.ifIdWrite = !hazard;
    strobes.bubble    = hazard;
  end

endmodule

// File: rtl/hzd_datapath.sv
module hzd_datapath
  import hzd_pkg::*;
#(
  parameter int unsigned XLEN    = 32,
  parameter int unsigned CTRL_W  = 8,
  parameter int unsigned REG_W   = 5,
  parameter int unsigned RT_LSB  = 16,
  parameter int unsigned PC_STEP = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  stallStrobes_t     strobes,
  input  logic [XLEN-1:0]   fetchInstr,
  input  logic [CTRL_W-1:0] decodeCtrl,
  output logic [XLEN-1:0]   pc,
  output logic [XLEN-1:0]   ifIdInstr,
  output logic [CTRL_W-1:0] idExCtrl,
  output logic [REG_W-1:0]  idExRt
);

  localparam logic [XLEN-1:0] PC_INC = XLEN'(PC_STEP);

  always_ff @(posedge clk) begin
    if (rst) begin
      pc <= '0;
    end else if (strobes.pcWrite) begin
      pc <= pc + PC_INC;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ifIdInstr <= '0;
    end else if (strobes.ifIdWrite) begin
      ifIdInstr <= fetchInstr;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      idExCtrl <= '0;
      idExRt   <= '0;
    end else begin
      idExCtrl <= strobes.bubble ? '0 : decodeCtrl;
      idExRt   <= ifIdInstr[RT_LSB +: REG_W];
    end
  end

endmodule

// File: rtl/hazard_stall_unit.sv
module hazard_stall_unit
  import hzd_pkg::*;
#(
  parameter int unsigned XLEN      = 32,
  parameter int unsigned CTRL_W    = 8,
  parameter int unsigned REG_W     = 5,
  parameter int unsigned MEMRD_BIT = 0,
  parameter int unsigned RS_LSB    = 21,
  parameter int unsigned RT_LSB    = 16,
  parameter int unsigned PC_STEP   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [XLEN-1:0]   fetchInstr,
  input  logic [CTRL_W-1:0] decodeCtrl,
  output logic [XLEN-1:0]   pc,
  output logic [XLEN-1:0]   ifIdInstr,
  output logic [CTRL_W-1:0] idExCtrl,
  output logic [REG_W-1:0]  idExRt,
  output logic              pcWriteEn,
  output logic              ifIdWriteEn,
  output logic              stall
);

  stallStrobes_t strobes;
  logic          hazard;

  hzd_ctrl #(
    .XLEN(XLEN), .REG_W(REG_W), .RS_LSB(RS_LSB), .RT_LSB(RT_LSB)
  ) uCtrl (
    .idExMemRead(idExCtrl[MEMRD_BIT]),
    .idExRt     (idExRt),
    .ifIdInstr  (ifIdInstr),
    .hazard     (hazard),
    .strobes    (strobes)
  );

  hzd_datapath #(
    .XLEN(XLEN), .CTRL_W(CTRL_W), .REG_W(REG_W),
    .RT_LSB(RT_LSB), .PC_STEP(PC_STEP)
  ) uPath (
    .clk       (clk),
    .rst       (rst),
    .strobes   (strobes),
    .fetchInstr(fetchInstr),
    .decodeCtrl(decodeCtrl),
    .pc        (pc),
    .ifIdInstr (ifIdInstr),
    .idExCtrl  (idExCtrl),
    .idExRt    (idExRt)
  );

  assign pcWriteEn   = strobes.pcWrite;
  assign ifIdWriteEn = strobes.ifIdWrite;
  assign stall       = hazard;

endmodule

// File: rtl/hazard_stall_unit_chk.sv
module hazard_stall_unit_chk #(
  parameter int unsigned XLEN   = 32,
  parameter int unsigned CTRL_W = 8,
  parameter int unsigned REG_W  = 5
) (
  input logic              clk,
  input logic              rst,
  input logic [XLEN-1:0]   pc,
  input logic [XLEN-1:0]   ifIdInstr,
  input logic [CTRL_W-1:0] idExCtrl,
  input logic [REG_W-1:0]  idExRt,
  input logic              pcWriteEn,
  input logic              ifIdWriteEn,
  input logic              stall
);

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (pc == '0 && ifIdInstr == '0 && idExCtrl == '0 && idExRt == '0));

  assert_detect_R2: assert property (@(posedge clk) disable iff (rst)
    stall == (idExCtrl[0] && (idExRt == ifIdInstr[25:21] || idExRt == ifIdInstr[20:16])));

  assert_enables_R3: assert property (@(posedge clk) disable iff (rst)
    (pcWriteEn == !stall) && (ifIdWriteEn == !stall));

  assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
    stall |=> ($stable(pc) && $stable(ifIdInstr)));

  assert_bubble_R5: assert property (@(posedge clk) disable iff (rst)
    stall |=> (idExCtrl == '0));

  assert_pc_step_R6: assert property (@(posedge clk) disable iff (rst)
    !stall |=> (pc == $past(pc) + XLEN'(4)));

  assert_single_stall_R7: assert property (@(posedge clk) disable iff (rst)
    stall |=> !stall);

endmodule

bind hazard_stall_unit hazard_stall_unit_chk #(
  .XLEN(XLEN), .CTRL_W(CTRL_W), .REG_W(REG_W)
) uChk (
  .clk        (clk),
  .rst        (rst),
  .pc         (pc),
  .ifIdInstr  (ifIdInstr),
  .idExCtrl   (idExCtrl),
  .idExRt     (idExRt),
  .pcWriteEn  (pcWriteEn),
  .ifIdWriteEn(ifIdWriteEn),
  .stall      (stall)
);

// File: tb/tb_hazard_stall_unit.sv
module tb_hazard_stall_unit;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] fetchInstr = '0;
  logic [7:0]  decodeCtrl = '0;
  logic [31:0] pc, ifIdInstr;
  logic [7:0]  idExCtrl;
  logic [4:0]  idExRt;
  logic        pcWriteEn, ifIdWriteEn, stall;

  int unsigned nChecks = 0;
  int unsigned nFails  = 0;
  int unsigned stallCount = 0;
  bit          done = 1'b0;

  // bench model of the architectural state
  logic [31:0] mPc = '0, mIfId = '0;
  logic [7:0]  mCtrl = '0;
  logic [4:0]  mRt = '0;

  always #4 clk = ~clk;  // 125 MHz

  hazard_stall_unit dut (
    .clk(clk), .rst(rst), .fetchInstr(fetchInstr), .decodeCtrl(decodeCtrl),
    .pc(pc), .ifIdInstr(ifIdInstr), .idExCtrl(idExCtrl), .idExRt(idExRt),
    .pcWriteEn(pcWriteEn), .ifIdWriteEn(ifIdWriteEn), .stall(stall)
  );

  function automatic logic [31:0] mkAlu(input logic [4:0] rs, input logic [4:0] rt, input logic [4:0] rd);
    return {6'h00, rs, rt, rd, 11'h020};
  endfunction

  function automatic logic [31:0] mkLoad(input logic [4:0] base, input logic [4:0] rt);
    return {6'h23, base, rt, 16'h0000};
  endfunction

  function automatic logic expHazard(input logic [7:0] c, input logic [4:0] rt, input logic [31:0] ins);
    return c[0] && (rt == ins[25:21] || rt == ins[20:16]);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // One cycle: entered and left at a falling edge.
  task automatic cycle(input logic [31:0] fi, input logic [7:0] dc);
    logic eh;
    fetchInstr = fi;
    decodeCtrl = dc;
    #1;
    eh = expHazard(mCtrl, mRt, mIfId);
    check("R2 stall", {31'b0, stall}, {31'b0, eh});
    check("R3 enables", {30'b0, pcWriteEn, ifIdWriteEn}, {30'b0, !eh, !eh});
    if (stall) stallCount++;
    mRt   = mIfId[20:16];
    mCtrl = eh ? 8'h00 : dc;
    if (!eh) begin
      mPc   = mPc + 32'd4;
      mIfId = fi;
    end
    @(negedge clk);
    check(eh ? "R4 pc" : "R6 pc", pc, mPc);
    check(eh ? "R4 ifId" : "R6 ifId", ifIdInstr, mIfId);
    check(eh ? "R5 ctrl" : "R6 ctrl", {24'b0, idExCtrl}, {24'b0, mCtrl});
    check("R6 rt", {27'b0, idExRt}, {27'b0, mRt});
  endtask

  initial begin
    #(8 * 100000);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    check("R1 pc", pc, 32'h0);
    check("R1 ifId", ifIdInstr, 32'h0);
    check("R1 ctrl", {24'b0, idExCtrl}, 32'h0);
    check("R1 rt", {27'b0, idExRt}, 32'h0);
    rst = 1'b0;

    // directed: load then dependent add -> exactly one bubble (R7)
    repeat (2) cycle(32'h0, 8'h00);
    stallCount = 0;
    cycle(mkLoad(5'd1, 5'd5), 8'h00);
    cycle(mkAlu(5'd5, 5'd2, 5'd9), 8'h01);   // decoder marks the load
    cycle(mkAlu(5'd3, 5'd4, 5'd10), 8'h06);  // stall cycle, fetch repeated
    cycle(mkAlu(5'd3, 5'd4, 5'd10), 8'h06);
    cycle(32'h0, 8'h02);
    check("R7 one bubble per pair", stallCount, 32'd1);

    // directed: dependence on second source field
    repeat (2) cycle(32'h0, 8'h00);
    stallCount = 0;
    cycle(mkLoad(5'd0, 5'd7), 8'h00);
    cycle(mkAlu(5'd2, 5'd7, 5'd9), 8'h01);
    cycle(32'h0, 8'h06);
    cycle(32'h0, 8'h06);
    check("R7 second source one bubble", stallCount, 32'd1);

    // directed: load then independent add -> no bubble
    repeat (2) cycle(32'h0, 8'h00);
    stallCount = 0;
    cycle(mkLoad(5'd1, 5'd5), 8'h00);
    cycle(mkAlu(5'd6, 5'd7, 5'd9), 8'h01);
    cycle(32'h0, 8'h06);
    cycle(32'h0, 8'h00);
    check("R8 independent no bubble", stallCount, 32'd0);

    // constrained random: few register numbers, frequent loads
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] ins;
      logic [7:0]  dc;
      ins = $urandom();
      ins[25:21] = 5'($urandom_range(0, 3));
      ins[20:16] = 5'($urandom_range(0, 3));
      dc = 8'($urandom());
      dc[0] = ($urandom_range(0, 9) < 4);
      cycle(ins, dc);
    end

    // reset mid-run
    rst = 1'b1;
    @(negedge clk);
    check("R1 pc after run", pc, 32'h0);
    check("R1 ctrl after run", {24'b0, idExCtrl}, 32'h0);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    done = 1'b1;
    $finish;
  end

endmodule